// File: doc/BRIEF.md
# External Bus Address Decoder with Diagnostic LED Latch

This block sits between a small controller's 16-bit external bus and the devices on that bus. It works out which device an access is meant for. Data-space accesses in the lower half of the map go to a data RAM. Data-space accesses in the upper half go to code memory, except in one protected window, which is split into 32-byte I/O select blocks. Program fetches in the upper half go to code memory, but never inside that window. Because of this gap, a data write aimed at an I/O register cannot land in a RAM that is serving as code store.

The block has two register functions, both driven from decoded I/O blocks. The first is a byte-wide latch that drives eight diagnostic LEDs. The second is a peripheral reset generator. A write to its block starts a fixed-length reset pulse, run by a two-state machine. The state `P_IDLE` moves to `P_ACTIVE` on a write start to the reset block. `P_ACTIVE` stays for `PULSE_LEN` cycles and then returns to `P_IDLE` when its counter reaches the last count. A write start is the first clock edge at which the write strobe is sampled low.

All bus strobes are active-low and synchronous to `clk`. Every chip enable and select is active-low.

Top module: `xbus_decode`

## Requirements
- R1: A data access (read strobe or write strobe low, fetch strobe high) with addr[15]=0 drives `ram_ce_n` low. `ram_ce_n` is never low when addr[15]=1.
- R2: `code_ce_n` is low for any fetch or data access with addr[15]=1 and addr outside FF00h–FFDFh. This includes FFE0h–FFFFh and 8000h–FEFFh.
- R3: `code_ce_n` stays high for every address in FF00h–FFDFh. In that window a data access drives `io_sel_n[k]` low, where k = (addr−FF00h)/32, for k = 0..6.
- R4: A fetch with addr[15]=0, a fetch inside FF00h–FFDFh, an idle bus, and a fetch together with a read or write strobe (a clash) assert no enable.
- R5: At most one of `ram_ce_n`, `code_ce_n` and the `io_sel_n` lines is low at any time.
- R6: A write start in block 6 (FFC0h–FFDFh) loads `wdata` into `led` at that clock edge. The new value is visible after that edge. `led[i]=1` means LED i is on, so 00h turns all LEDs off and FFh turns all on.
- R7: `led` holds its value for reads, for writes elsewhere, and for cycles after a write start while the strobe stays low.
- R8: A write start in block 5 (FFA0h–FFBFh) raises `per_rst` after that edge. `per_rst` stays high for exactly 16 consecutive cycles.
- R9: A write start to block 5 while a pulse is running neither extends nor restarts it. A write strobe held low for many cycles produces only one pulse.
- R10: While `rst_n` is low, `led` is 00h and `per_rst` is 0. A running pulse is aborted and does not resume after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data byte |
| rd_n | input | 1 | Data read strobe, active-low |
| wr_n | input | 1 | Data write strobe, active-low |
| fetch_n | input | 1 | Program fetch strobe, active-low |
| ram_ce_n | output | 1 | Data RAM enable, active-low |
| code_ce_n | output | 1 | Code memory enable, active-low |
| io_sel_n | output | 7 | I/O block selects, active-low, one per 32-byte block |
| led | output | 8 | Diagnostic LED drive, 1 = on |
| per_rst | output | 1 | Peripheral reset request, active-high |

## Verification
The enables and selects are combinational. The bench drives each table row on a falling clock edge and compares all enables within the same half cycle. `led` and `per_rst` both change at the first rising edge that samples the write strobe low. The bench therefore checks that `led` still holds its old value before that edge and holds the new value in the half cycle after it. A monitor samples `per_rst` one time unit after every rising edge and counts the high samples across a forty-cycle window after each trigger. That window catches pulses that run one cycle short or long, retriggers, and restarts caused by a held strobe.

// File: rtl/xbd_pkg.sv
package xbd_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_DATA,
        ACC_FETCH,
        ACC_CLASH
    } acc_kind_t;

    typedef enum logic [0:0] {
        P_IDLE,
        P_ACTIVE
    } prst_state_t;

endpackage

// File: rtl/xbd_map.sv
module xbd_map
    import xbd_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]   WIN_BASE = 16'hFF00,
    parameter logic [ADDR_W-1:0]   WIN_LAST = 16'hFFDF,
    parameter int unsigned         BLK_LOG2 = 5,
    parameter int unsigned         NUM_IO   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              fetch_n,
    output logic              ram_ce_n,
    output logic              code_ce_n,
    output logic [NUM_IO-1:0] io_sel_n
);

    localparam logic [ADDR_W-1:0] BLK_SIZE = ADDR_W'(1 << BLK_LOG2);

    acc_kind_t kind;
    logic      upper;
    logic      in_win;

    always_comb begin
        if (!fetch_n && (!rd_n || !wr_n))
            kind = ACC_CLASH;
        else if (!fetch_n)
            kind = ACC_FETCH;
        else if (!rd_n || !wr_n)
            kind = ACC_DATA;
        else
            kind = ACC_IDLE;
    end

    assign upper  = addr[ADDR_W-1];
    assign in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);

    always_comb begin
        ram_ce_n  = 1'b1;
        code_ce_n = 1'b1;
        unique case (kind)
            ACC_DATA: begin
                ram_ce_n  = upper;
                code_ce_n = !(upper && !in_win);
            end
            ACC_FETCH: begin
                code_ce_n = !(upper && !in_win);
            end
            ACC_IDLE, ACC_CLASH: begin
                ram_ce_n  = 1'b1;
                code_ce_n = 1'b1;
            end
            default: begin
                ram_ce_n  = 1'b1;
                code_ce_n = 1'b1;
            end
        endcase
    end

    for (genvar k = 0; k < NUM_IO; k++) begin : g_iosel
        localparam logic [ADDR_W-1:0] LO = WIN_BASE + ADDR_W'(k) * BLK_SIZE;
        localparam logic [ADDR_W-1:0] HI = LO + BLK_SIZE - ADDR_W'(1);
        assign io_sel_n[k] = !((kind == ACC_DATA) && (addr >= LO) && (addr <= HI));
    end

    // R5: no two devices selected together
    a_r5_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_ce_n, ~code_ce_n, ~io_sel_n}));

    // R1: RAM only in the lower half
    a_r1_ram_lower: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> !addr[ADDR_W-1]);

    // R3: code memory never enabled inside the I/O window
    a_r3_code_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ce_n |-> !((addr >= WIN_BASE) && (addr <= WIN_LAST)));

    // R4: a clashing access enables nothing
    a_r4_clash_none: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_n && !rd_n) |-> (ram_ce_n && code_ce_n && (&io_sel_n)));

endmodule

// File: rtl/xbd_wstart.sv
module xbd_wstart (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic wr_start
);

    logic wr_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_n_q <= 1'b1;
        else
            wr_n_q <= wr_n;
    end

    assign wr_start = !wr_n && wr_n_q;

    // R9: a held strobe yields a start only in its first cycle
    a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

endmodule

// File: rtl/xbd_led_latch.sv
module xbd_led_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] led
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            led <= '0;
        else if (load)
            led <= wdata;
    end

    // R7: value held when not loaded
    a_r7_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(led));

    // R6: loaded value appears after the edge
    a_r6_led_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (led == $past(wdata)));

endmodule

// File: rtl/xbd_prst_fsm.sv
module xbd_prst_fsm
    import xbd_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic prst
);

    localparam int unsigned      CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PULSE_LEN - 1);
    localparam int unsigned      RUN_W = CNT_W + 1;

    prst_state_t      state, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            P_IDLE:   if (trig)         nxt = P_ACTIVE;
            P_ACTIVE: if (cnt == LAST)  nxt = P_IDLE;
            default:                    nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= P_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == P_ACTIVE && nxt == P_ACTIVE) ? cnt + CNT_W'(1) : '0;
        end
    end

    always_comb begin
        unique case (state)
            P_IDLE:   prst = 1'b0;
            P_ACTIVE: prst = 1'b1;
            default:  prst = 1'b0;
        endcase
    end

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (prst)
            run_q <= run_q + RUN_W'(1);
        else
            run_q <= '0;
    end

    // R8: every pulse ends after exactly PULSE_LEN cycles
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prst) |-> (run_q == RUN_W'(PULSE_LEN)));

    // R9: a pulse never outlasts its length
    a_r9_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(PULSE_LEN));

    // R8: a pulse starts only from a trigger
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!prst && !trig) |=> !prst);

endmodule

// File: rtl/xbus_decode.sv
module xbus_decode #(
    parameter int unsigned         ADDR_W    = 16,
    parameter int unsigned         DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   WIN_BASE  = 16'hFF00,
    parameter logic [ADDR_W-1:0]   WIN_LAST  = 16'hFFDF,
    parameter int unsigned         BLK_LOG2  = 5,
    parameter int unsigned         LED_BLK   = 6,
    parameter int unsigned         PRST_BLK  = 5,
    parameter int unsigned         PULSE_LEN = 16,
    localparam int unsigned        NUM_IO    = (int'(WIN_LAST) - int'(WIN_BASE) + 1) >> BLK_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              fetch_n,
    output logic              ram_ce_n,
    output logic              code_ce_n,
    output logic [NUM_IO-1:0] io_sel_n,
    output logic [DATA_W-1:0] led,
    output logic              per_rst
);

    logic wr_start;
    logic led_load;
    logic prst_trig;

    xbd_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST),
        .BLK_LOG2 (BLK_LOG2),
        .NUM_IO   (NUM_IO)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .fetch_n   (fetch_n),
        .ram_ce_n  (ram_ce_n),
        .code_ce_n (code_ce_n),
        .io_sel_n  (io_sel_n)
    );

    xbd_wstart u_wstart (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .wr_start (wr_start)
    );

    assign led_load  = wr_start && !io_sel_n[LED_BLK];
    assign prst_trig = wr_start && !io_sel_n[PRST_BLK];

    xbd_led_latch #(
        .DATA_W (DATA_W)
    ) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (led_load),
        .wdata (wdata),
        .led   (led)
    );

    xbd_prst_fsm #(
        .PULSE_LEN (PULSE_LEN)
    ) u_prst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (prst_trig),
        .prst  (per_rst)
    );

    // R2: upper-half access outside the window reaches code memory
    a_r2_code_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_n && rd_n && wr_n && addr[ADDR_W-1] && (addr > WIN_LAST)) |-> !code_ce_n);

endmodule

// File: tb/xbus_decode_tb.sv
module xbus_decode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        fetch_n = 1'b1;
    logic        ram_ce_n, code_ce_n, per_rst;
    logic [6:0]  io_sel_n;
    logic [7:0]  led;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xbus_decode u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n),
        .ram_ce_n(ram_ce_n), .code_ce_n(code_ce_n), .io_sel_n(io_sel_n),
        .led(led), .per_rst(per_rst)
    );

    // {addr, rd_n, wr_n, fetch_n, ram_ce_n, code_ce_n, io_sel_n}
    localparam int NV = 17;
    localparam logic [27:0] VEC [NV] = '{
        {16'h0000, 3'b111, 2'b11, 7'h7F},
        {16'h1234, 3'b011, 2'b01, 7'h7F},
        {16'h7FFF, 3'b101, 2'b01, 7'h7F},
        {16'h8000, 3'b011, 2'b10, 7'h7F},
        {16'hFEFF, 3'b011, 2'b10, 7'h7F},
        {16'hFF00, 3'b011, 2'b11, 7'h7E},
        {16'hFF3F, 3'b101, 2'b11, 7'h7D},
        {16'hFF45, 3'b011, 2'b11, 7'h7B},
        {16'hFFA0, 3'b011, 2'b11, 7'h5F},
        {16'hFFDF, 3'b011, 2'b11, 7'h3F},
        {16'hFFE0, 3'b011, 2'b10, 7'h7F},
        {16'hFFFF, 3'b101, 2'b10, 7'h7F},
        {16'h8000, 3'b110, 2'b10, 7'h7F},
        {16'hFF10, 3'b110, 2'b11, 7'h7F},
        {16'h0100, 3'b110, 2'b11, 7'h7F},
        {16'hFFF0, 3'b110, 2'b10, 7'h7F},
        {16'h8000, 3'b010, 2'b11, 7'h7F}
    };

    always @(posedge clk) begin
        #1;
        if (per_rst) hi_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        addr = a; wdata = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 led in reset", 32'(led), 32'h00);
        check("R10 per_rst in reset", 32'(per_rst), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: decode table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr    = VEC[i][27:12];
            rd_n    = VEC[i][11];
            wr_n    = VEC[i][10];
            fetch_n = VEC[i][9];
            #1;
            check($sformatf("R1 R2 R3 R4 decode row %0d", i),
                  32'({ram_ce_n, code_ce_n, io_sel_n}), 32'(VEC[i][8:0]));
            check($sformatf("R5 single enable row %0d", i),
                  32'($countones({~ram_ce_n, ~code_ce_n, ~io_sel_n}) <= 1), 32'h1);
        end
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; fetch_n = 1'b1;

        // R6: LED loads, timing and all-off / all-on
        bus_write(16'hFFC0, 8'hFF, 1);
        check("R6 led all on", 32'(led), 32'hFF);
        @(negedge clk);
        addr = 16'hFFDF; wdata = 8'h00; wr_n = 1'b0;
        #1;
        check("R6 led not before edge", 32'(led), 32'hFF);
        @(negedge clk);
        wr_n = 1'b1;
        check("R6 led all off", 32'(led), 32'h00);
        bus_write(16'hFFD3, 8'hA5, 1);
        check("R6 led pattern", 32'(led), 32'hA5);

        // R7: hold on other accesses
        bus_write(16'hFF20, 8'h3C, 1);
        check("R7 led hold io write", 32'(led), 32'hA5);
        bus_write(16'h1234, 8'h77, 1);
        check("R7 led hold ram write", 32'(led), 32'hA5);
        @(negedge clk);
        addr = 16'hFFC0; wdata = 8'h11; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        check("R7 led hold read", 32'(led), 32'hA5);
        @(negedge clk);
        addr = 16'hFFC0; wdata = 8'h5A; wr_n = 1'b0;
        @(negedge clk);
        wdata = 8'h99;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        check("R7 led hold held strobe", 32'(led), 32'h5A);

        // R8: pulse length
        @(negedge clk);
        check("R8 per_rst idle", 32'(per_rst), 32'h0);
        hi_cnt = 0;
        bus_write(16'hFFA0, 8'h00, 1);
        check("R8 per_rst after edge", 32'(per_rst), 32'h1);
        repeat (40) @(negedge clk);
        check("R8 pulse length", 32'(hi_cnt), 32'd16);
        check("R8 per_rst ends", 32'(per_rst), 32'h0);

        // R9: retrigger ignored, held strobe counts once
        hi_cnt = 0;
        bus_write(16'hFFB7, 8'h00, 1);
        repeat (5) @(negedge clk);
        bus_write(16'hFFA0, 8'h00, 1);
        repeat (40) @(negedge clk);
        check("R9 retrigger ignored", 32'(hi_cnt), 32'd16);
        hi_cnt = 0;
        bus_write(16'hFFA0, 8'h00, 25);
        repeat (40) @(negedge clk);
        check("R9 held strobe single pulse", 32'(hi_cnt), 32'd16);

        // R10: reset mid-pulse
        bus_write(16'hFFA0, 8'h00, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 per_rst aborted", 32'(per_rst), 32'h0);
        check("R10 led cleared", 32'(led), 32'h00);
        @(negedge clk);
        rst_n = 1'b1;
        hi_cnt = 0;
        repeat (20) @(negedge clk);
        check("R10 no resume", 32'(hi_cnt), 32'd0);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule